// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block produces one pulse-width-modulated output from a two-register, word-addressed write/read port. The control register carries a run bit, a stored select bit, an update-hold bit and a clock divide code. The divide code is a 4-bit coarse field plus a half-step bit. The count register carries a 10-bit period and a 10-bit high time. The input clock is divided by a power of two. Each divided tick advances a period counter. The output is high for the first high-time ticks of every period.

Software sets the hold bit, rewrites the counts and divide code, then clears the hold bit. The staged values are then taken over together. If the channel is stopped they are taken over at once. If it is running they are taken over at the next period boundary, so no period is ever cut short or mixed. A zero period or zero high time is never allowed to run, so a 0% duty cycle cannot be produced.

Top module: `pwm_chan`

## Requirements
- R1: After reset the output is low and both registers read as zero.
- R2: The control register is at byte offset 0x0. Its fields are run at bit 0, select at bit 4, hold at bit 11, half-step at bit 15 and coarse divide at bits 19:16. The count register is at byte offset 0x4. Its fields are period at bits 25:16 and high time at bits 9:0. Reads return the last written field values. All other bits read as zero.
- R3: While running, each period lasts `period` divided ticks. The output is high for the first `high` ticks of each period. The first period starts in the cycle after the run bit is accepted.
- R4: One divided tick lasts 2^n input clocks, where n = 2*coarse + half-step. A value of n above 24 is treated as 24.
- R5: If the high time is greater than or equal to the period, the output stays high for the whole time the channel runs.
- R6: A write that sets the run bit is refused if the active period or active high time, taking into account an update that lands in that same cycle, would be zero. In that case the run bit reads 0 and the output stays low.
- R7: While the hold bit is 1, count and divide writes only change the readable staged values and do not change the output. After the hold bit returns to 0, the staged set is applied at the next period boundary if the channel is running, or on the next clock if it is stopped.
- R8: While running, a staged update that contains a zero period or zero high time is discarded at the boundary, and the waveform continues unchanged.
- R9: Writing the run bit as 0 drives the output low from the next cycle. A later restart begins at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address (0x0 control, 0x4 count) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The hardest situation to reach is a held update landing on a running channel. The bench must show that the old waveform carries on exactly until the period boundary and that the new one then starts from its first high tick. To get there, the bench enables the channel at a known edge and queues the expected output for the remaining old period followed by the new waveform. It then issues the hold, count and release writes back to back, one edge each, so that the boundary falls at a cycle computed from the old period. The same aligned-start technique is used to show that a zero-valued update is dropped without disturbing the waveform.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  // register word indices (byte address / 4)
  localparam int CTRL_IDX  = 0;
  localparam int COUNT_IDX = 1;

  // control register field positions
  localparam int RUN_BIT  = 0;
  localparam int SEL_BIT  = 4;
  localparam int HOLD_BIT = 11;
  localparam int HALF_BIT = 15;
  localparam int DIV_LSB  = 16;

  // count register field positions
  localparam int PER_LSB  = 16;
  localparam int HIGH_LSB = 0;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              boundary,
  output logic [31:0]       rdata,
  output logic              run_q,
  output logic              hold_q,
  output logic              pend_q,
  output logic [CNT_W-1:0]  act_per,
  output logic [CNT_W-1:0]  act_high,
  output logic [DIV_W-1:0]  act_div,
  output logic              act_half
);
  localparam int IDX_W = ADDR_W - 2;

  logic [CNT_W-1:0] stg_per, stg_per_d, stg_high, stg_high_d;
  logic [DIV_W-1:0] stg_div, stg_div_d;
  logic             stg_half, stg_half_d;
  logic             sel_q, sel_d, hold_d, run_d, pend_d;
  logic [CNT_W-1:0] act_per_d, act_high_d;
  logic [DIV_W-1:0] act_div_d;
  logic             act_half_d;
  logic [IDX_W-1:0] idx;
  logic             wr_ctrl, wr_cnt, apply, copy, stg_bad, next_ok;
  logic [31:0]      rd_ctrl, rd_cnt;
  logic             unused_bits;

  assign idx         = addr[ADDR_W-1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  always_comb begin
    wr_ctrl    = wr && (idx == IDX_W'(CTRL_IDX));
    wr_cnt     = wr && (idx == IDX_W'(COUNT_IDX));

    stg_per_d  = wr_cnt  ? wdata[PER_LSB  +: CNT_W] : stg_per;
    stg_high_d = wr_cnt  ? wdata[HIGH_LSB +: CNT_W] : stg_high;
    stg_div_d  = wr_ctrl ? wdata[DIV_LSB  +: DIV_W] : stg_div;
    stg_half_d = wr_ctrl ? wdata[HALF_BIT]          : stg_half;
    sel_d      = wr_ctrl ? wdata[SEL_BIT]           : sel_q;
    hold_d     = wr_ctrl ? wdata[HOLD_BIT]          : hold_q;

    // staged set moves over when not held: at once if stopped, else at boundary
    apply      = pend_q && !hold_q && (!run_q || boundary);
    stg_bad    = (stg_per == '0) || (stg_high == '0);
    copy       = apply && !(run_q && stg_bad);

    act_per_d  = copy ? stg_per  : act_per;
    act_high_d = copy ? stg_high : act_high;
    act_div_d  = copy ? stg_div  : act_div;
    act_half_d = copy ? stg_half : act_half;

    pend_d     = (wr_ctrl && !wdata[HOLD_BIT]) || (wr_cnt && !hold_q) ||
                 (pend_q && !apply);

    next_ok    = (act_per_d != '0) && (act_high_d != '0);
    run_d      = wr_ctrl ? (wdata[RUN_BIT] && next_ok) : run_q;

    rd_ctrl                          = '0;
    rd_ctrl[RUN_BIT]                 = run_q;
    rd_ctrl[SEL_BIT]                 = sel_q;
    rd_ctrl[HOLD_BIT]                = hold_q;
    rd_ctrl[HALF_BIT]                = stg_half;
    rd_ctrl[DIV_LSB +: DIV_W]        = stg_div;
    rd_cnt                           = '0;
    rd_cnt[PER_LSB  +: CNT_W]        = stg_per;
    rd_cnt[HIGH_LSB +: CNT_W]        = stg_high;

    if (idx == IDX_W'(CTRL_IDX))       rdata = rd_ctrl;
    else if (idx == IDX_W'(COUNT_IDX)) rdata = rd_cnt;
    else                               rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_per  <= '0;
      stg_high <= '0;
      stg_div  <= '0;
      stg_half <= 1'b0;
      sel_q    <= 1'b0;
      hold_q   <= 1'b0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      act_per  <= '0;
      act_high <= '0;
      act_div  <= '0;
      act_half <= 1'b0;
    end else begin
      stg_per  <= stg_per_d;
      stg_high <= stg_high_d;
      stg_div  <= stg_div_d;
      stg_half <= stg_half_d;
      sel_q    <= sel_d;
      hold_q   <= hold_d;
      run_q    <= run_d;
      pend_q   <= pend_d;
      act_per  <= act_per_d;
      act_high <= act_high_d;
      act_div  <= act_div_d;
      act_half <= act_half_d;
    end
  end
endmodule

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale #(
  parameter int MAX_EXP = 24,
  parameter int EXP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick
);
  logic [MAX_EXP-1:0] pre_cnt, pre_cnt_d, term;

  always_comb begin
    term      = ~({MAX_EXP{1'b1}} << exp_i);
    tick      = run && (pre_cnt == term);
    if (!run || tick) pre_cnt_d = '0;
    else              pre_cnt_d = pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt_d;
  end
endmodule

// File: rtl/pwm_chan_period.sv
module pwm_chan_period #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] high,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_d;
  logic             last;

  always_comb begin
    last     = (cnt == per - 1'b1);
    boundary = tick && last;
    if (!run || boundary) cnt_d = '0;
    else if (tick)        cnt_d = cnt + 1'b1;
    else                  cnt_d = cnt;
    pwm_o    = run && (cnt < high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W   = 10,
  parameter int DIV_W   = 4,
  parameter int MAX_EXP = 24,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pwm_out
);
  localparam int EXP_W = $clog2(MAX_EXP + 1);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             run_q, hold_q, pend_q, boundary, tick;
  logic [CNT_W-1:0] act_per, act_high, cnt;
  logic [DIV_W-1:0] act_div;
  logic             act_half;
  logic [DIV_W:0]   exp_raw;
  logic [EXP_W-1:0] act_exp;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    exp_raw = {act_div, act_half};
    if (int'(exp_raw) > MAX_EXP) act_exp = EXP_W'(MAX_EXP);
    else                         act_exp = EXP_W'(exp_raw);
  end

  pwm_chan_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .boundary(boundary), .rdata(reg_rdata),
    .run_q(run_q), .hold_q(hold_q), .pend_q(pend_q),
    .act_per(act_per), .act_high(act_high), .act_div(act_div),
    .act_half(act_half)
  );

  pwm_chan_prescale #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(run_q), .exp_i(act_exp), .tick(tick)
  );

  pwm_chan_period #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_sync_n), .run(run_q), .tick(tick),
    .per(act_per), .high(act_high), .cnt(cnt), .boundary(boundary),
    .pwm_o(pwm_out)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W   = 10,
  parameter int MAX_EXP = 24,
  parameter int ADDR_W  = 3,
  parameter int EXP_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              pwm_out,
  input logic              run_q,
  input logic              hold_q,
  input logic [CNT_W-1:0]  act_per,
  input logic [CNT_W-1:0]  act_high,
  input logic [EXP_W-1:0]  act_exp,
  input logic [CNT_W-1:0]  cnt
);
  logic unused_chk;
  assign unused_chk = ^{reg_addr, reg_wdata};

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[ADDR_W-1:2] == '0 && !reg_wdata[0]) |=> !pwm_out);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ($stable(act_per) && $stable(act_high) && $stable(act_exp)));

  // R6
  run_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (act_per != '0 && act_high != '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt < act_per));

  // R4
  exp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_exp) <= MAX_EXP);

  // R5
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_high >= act_per) |-> pwm_out);
endmodule

bind pwm_chan pwm_chan_chk #(
  .CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .ADDR_W(ADDR_W), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pwm_out(pwm_out), .run_q(run_q), .hold_q(hold_q),
  .act_per(act_per), .act_high(act_high), .act_exp(act_exp), .cnt(cnt)
);

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];   // item = req*2 + expected bit
  int item;

  pwm_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // scoreboard monitor: one expected output bit per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      checks++;
      if (pwm_out !== item[0]) begin
        fails++;
        $display("FAIL R%0d pwm_out actual %0b expected %0b at %0t",
                 item >> 1, pwm_out, item[0], $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] e, input int req);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL R%0d read 0x%0h actual 0x%08h expected 0x%08h", req, a, reg_rdata, e);
    end
  endtask

  task automatic push_const(input bit v, input int n, input int req);
    for (int i = 0; i < n; i++) exp_q.push_back(req * 2 + int'(v));
  endtask

  task automatic push_wave(input int per, input int hi, input int n, input int len, input int req);
    for (int k = 0; k < len; k++)
      exp_q.push_back(req * 2 + (((k >> n) % per) < hi ? 1 : 0));
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1: reset state
    rd_check(3'h0, 32'h0, 1);
    rd_check(3'h4, 32'h0, 1);
    push_const(1'b0, 4, 1);
    drain();

    // R6: run refused with zero counts, then with zero high time
    wr(3'h0, 32'h1);
    push_const(1'b0, 8, 6);
    rd_check(3'h0, 32'h0, 6);
    drain();
    wr(3'h4, (32'd5 << 16));
    wr(3'h0, 32'h1);
    push_const(1'b0, 8, 6);
    rd_check(3'h0, 32'h0, 6);
    drain();

    // R2: field positions, reserved bits, staged readback (R6 refuses run again)
    wr(3'h0, 32'hFFFF_FFFF);
    rd_check(3'h0, 32'h000F_8810, 2);
    wr(3'h4, 32'hFFFF_FFFF);
    rd_check(3'h4, 32'h03FF_03FF, 2);
    wr(3'h0, 32'h0);
    rd_check(3'h0, 32'h0, 2);

    // R3: basic waveform, period 5, high 2, no division
    wr(3'h4, (32'd5 << 16) | 32'd2);
    wr(3'h0, 32'h1);
    push_wave(5, 2, 0, 40, 3);
    drain();
    rd_check(3'h0, 32'h1, 3);

    // R9: stop drives low, restart at start of period
    wr(3'h0, 32'h0);
    push_const(1'b0, 6, 9);
    drain();
    wr(3'h0, 32'h1);
    push_wave(5, 2, 0, 12, 9);
    drain();

    // R8: zero-high update while running is dropped
    wr(3'h0, 32'h0);
    wr(3'h0, 32'h1);
    push_wave(5, 2, 0, 40, 8);
    wr(3'h4, (32'd5 << 16));
    drain();
    wr(3'h4, (32'd5 << 16) | 32'd2);
    wr(3'h0, 32'h0);

    // R7: held update lands at the period boundary
    wr(3'h0, 32'h1);
    push_wave(5, 2, 0, 5, 7);
    push_wave(8, 4, 0, 32, 7);
    wr(3'h0, 32'h0000_0801);
    wr(3'h4, (32'd8 << 16) | 32'd4);
    wr(3'h0, 32'h1);
    drain();

    // R4: divide exponent 3 (coarse 1, half-step 1)
    wr(3'h0, 32'h0);
    wr(3'h4, (32'd4 << 16) | 32'd1);
    wr(3'h0, 32'h0001_8000);
    wr(3'h0, 32'h0001_8001);
    push_wave(4, 1, 3, 64, 4);
    drain();
    // R4: divide exponent 1 (half-step only)
    wr(3'h0, 32'h0);
    wr(3'h4, (32'd3 << 16) | 32'd2);
    wr(3'h0, 32'h0000_8000);
    wr(3'h0, 32'h0000_8001);
    push_wave(3, 2, 1, 24, 4);
    drain();

    // R5: high time beyond period keeps output high
    wr(3'h0, 32'h0);
    wr(3'h4, (32'd3 << 16) | 32'd7);
    wr(3'h0, 32'h1);
    push_wave(3, 7, 0, 20, 5);
    drain();

    wr(3'h0, 32'h0);
    summary();
    $finish;
  end
endmodule